// File: doc/BRIEF.md
# Power-On Reset Delay Timer

This block stretches the processor reset. It holds reset for a fixed number of cycles of its own free-running RC-derived clock, so the supply and the main oscillator can settle before code runs. Three events start the timed interval: the supply status going from failed to good, a watchdog timeout, and a recovery from stop mode. While the interval runs, the reset-hold output stays high. When the interval ends, the output drops and a single-cycle completion pulse is issued.

The stop-recovery event is the only one that can skip the delay. A run-delay bit, which comes from the stop-mode configuration, decides this. When the bit is set, stop recovery runs the full interval. When it is clear, the completion pulse comes at once and reset is never raised. The supply and watchdog events always run the full interval. All inputs are asynchronous to the RC clock and pass through a two-flop synchronizer. A rising-edge detector then starts the one-shot. A loss of supply raises the reset-hold output combinationally, without waiting for a clock edge.

Top module: `por_delay_timer`

## Requirements
- R1: While `rst` is high, `hold_rst` is 1 and `done_o` is 0. If `pwr_ok` is already 1 when `rst` falls, `hold_rst` falls, and `done_o` is 1 in the same cycle, exactly DELAY_CYCLES+3 clock edges after the first edge with `rst` low.
- R2: A rising edge on `pwr_ok` runs the full delay. `hold_rst` falls, together with a `done_o` pulse, DELAY_CYCLES+3 clock edges after the edge is applied. This total is 2 synchronizer stages, 1 start cycle and DELAY_CYCLES counting cycles.
- R3: A rising edge on `wdt_timeout` raises `hold_rst` again within 3 edges and releases it DELAY_CYCLES+3 edges after the edge is applied.
- R4: When `stop_delay_en` = 1, a rising edge on `stop_recover` runs the full delay with the same DELAY_CYCLES+3 latency.
- R5: When `stop_delay_en` = 0 and the timer is idle and released, a rising edge on `stop_recover` never raises `hold_rst`. It produces a `done_o` pulse on the 3rd edge after the event.
- R6: When `stop_delay_en` = 0, the watchdog and supply events still run the full DELAY_CYCLES+3 delay.
- R7: A start event that arrives while the timer is counting restarts the count. Release then comes DELAY_CYCLES+3 edges after the later event.
- R8: While `pwr_ok` is 0, `hold_rst` is 1, including before any clock edge. Watchdog and stop events give no `done_o` pulse in that time.
- R9: `done_o` is high for exactly one cycle per completed interval, and only while `hold_rst` is 0.
- R10: Only rising edges start the timer. A trigger input held high, or a falling edge, has no further effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running RC-derived clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply status, 1 = good (asynchronous) |
| wdt_timeout | input | 1 | Watchdog timeout event (asynchronous) |
| stop_recover | input | 1 | Stop-mode recovery event (asynchronous) |
| stop_delay_en | input | 1 | 1 = run the delay after stop recovery, 0 = release at once |
| hold_rst | output | 1 | Processor reset hold, active high |
| done_o | output | 1 | One-cycle pulse when an interval completes |

## Verification
The bench builds the timer with DELAY_CYCLES = 12 rather than the default of 500, which is 5 ms at 100 kHz. With the short delay, every release latency can be measured edge by edge, and each requirement's exact value can be checked in a run of a few hundred cycles. The short delay also leaves room to retrigger in the middle of a count, to drop the supply in the middle of an interval, and to hold a trigger input high for longer than a whole interval.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } por_state_e;

  localparam int unsigned IN_PWR  = 0;
  localparam int unsigned IN_WDT  = 1;
  localparam int unsigned IN_STOP = 2;
  localparam int unsigned IN_BYP  = 3;
  localparam int unsigned IN_NUM  = 4;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/por_edge.sv
module por_edge #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;

  a_r10_rise_single: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/por_counter.sv
module por_counter #(
  parameter int unsigned DELAY_CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic last
);
  localparam int unsigned CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = en && (cnt_q == LAST_VAL);

  always_ff @(posedge clk) begin
    if (rst || clear)    cnt_q <= '0;
    else if (en && !last) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_VAL);
  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 500,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic wdt_timeout,
  input  logic stop_recover,
  input  logic stop_delay_en,
  output logic hold_rst,
  output logic done_o
);
  import por_pkg::*;

  logic [IN_NUM-1:0] raw_in, sync_in;
  logic [2:0]        rise;
  logic              pwr_s, byp_s, pwr_rise, wdt_rise, stop_rise;
  logic              start, quick, last;
  por_state_e        state_q, state_d;
  logic              hold_q, done_q;

  assign raw_in[IN_PWR]  = pwr_ok;
  assign raw_in[IN_WDT]  = wdt_timeout;
  assign raw_in[IN_STOP] = stop_recover;
  assign raw_in[IN_BYP]  = stop_delay_en;

  por_sync #(.WIDTH(IN_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(sync_in)
  );

  por_edge #(.WIDTH(3)) u_edge (
    .clk(clk), .rst(rst), .level(sync_in[2:0]), .rise(rise)
  );

  assign pwr_s     = sync_in[IN_PWR];
  assign byp_s     = sync_in[IN_BYP];
  assign pwr_rise  = rise[IN_PWR];
  assign wdt_rise  = rise[IN_WDT];
  assign stop_rise = rise[IN_STOP];

  assign start = pwr_rise | wdt_rise | (stop_rise & byp_s);
  assign quick = stop_rise & ~byp_s & pwr_s & ~start & (state_q == ST_RUN);

  por_counter #(.DELAY_CYCLES(DELAY_CYCLES)) u_cnt (
    .clk(clk), .rst(rst),
    .clear(start || (state_q != ST_COUNT)),
    .en(state_q == ST_COUNT),
    .last(last)
  );

  always_comb begin
    state_d = state_q;
    if (!pwr_s)     state_d = ST_WAIT;
    else if (start) state_d = ST_COUNT;
    else if (state_q == ST_COUNT && last) state_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      hold_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= (state_d != ST_RUN);
      done_q  <= ((state_q == ST_COUNT) && (state_d == ST_RUN)) || quick;
    end
  end

  assign hold_rst = hold_q | ~pwr_ok;
  assign done_o   = done_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !hold_q);
  a_r8_hold_on_loss: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |-> hold_rst);
  a_r8_sync_low_holds: assert property (@(posedge clk) disable iff (rst)
    !pwr_s |=> (hold_q && !done_q));
  a_r2_release_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> done_q);
  a_r5_bypass_no_hold: assert property (@(posedge clk) disable iff (rst)
    quick |=> (!hold_q && done_q));
endmodule

// File: tb/tb_por_delay_timer.sv
module tb_por_delay_timer;
  localparam int unsigned D   = 12;
  localparam int          LAT = D + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0, wdt_timeout = 1'b0, stop_recover = 1'b0, stop_delay_en = 1'b1;
  logic hold_rst, done_o;
  int   errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  por_delay_timer #(.DELAY_CYCLES(D)) dut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .wdt_timeout(wdt_timeout),
    .stop_recover(stop_recover), .stop_delay_en(stop_delay_en),
    .hold_rst(hold_rst), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // src: 0 power (kept high), 1 watchdog, 2 stop (pulses cleared at edge 2)
  task automatic fire(input int src, input int lat, input int exp_hold, input string req);
    int n = 0, dn = 0, dc = 0, hi = 0, hold_at = 1;
    case (src)
      0: pwr_ok = 1'b1;
      1: wdt_timeout = 1'b1;
      default: stop_recover = 1'b1;
    endcase
    while (n < lat + 6) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 2) begin
        wdt_timeout  = 1'b0;
        stop_recover = 1'b0;
      end
      if (hold_rst) hi = 1;
      if (done_o) begin
        if (dc == 0) begin
          dn = n;
          hold_at = int'(hold_rst);
        end
        dc++;
      end
    end
    check({req, " release latency"}, dn, lat);
    check({req, " hold low at done"}, hold_at, 0);
    check({req, " one done pulse"}, dc, 1);
    check({req, " hold seen high"}, hi, exp_hold);
    check({req, " hold low after"}, int'(hold_rst), 0);
  endtask

  task automatic t_reset;
    cycles(3);
    check("R1 hold in reset", int'(hold_rst), 1);
    check("R1 done in reset", int'(done_o), 0);
    pwr_ok = 1'b1;
    cycles(2);
    check("R1 hold in reset with power", int'(hold_rst), 1);
    rst = 1'b0;
    fire(0, LAT, 1, "R1");
  endtask

  task automatic t_watchdog;
    fire(1, LAT, 1, "R3");
  endtask

  task automatic t_stop_delay;
    stop_delay_en = 1'b1;
    cycles(3);
    fire(2, LAT, 1, "R4");
  endtask

  task automatic t_stop_bypass;
    stop_delay_en = 1'b0;
    cycles(3);
    fire(2, 3, 0, "R5");
  endtask

  task automatic t_no_shortcut;
    stop_delay_en = 1'b0;
    cycles(3);
    fire(1, LAT, 1, "R6 watchdog");
    pwr_ok = 1'b0;
    cycles(4);
    fire(0, LAT, 1, "R6 power");
    stop_delay_en = 1'b1;
    cycles(3);
  endtask

  task automatic t_retrigger;
    int dseen = 0;
    wdt_timeout = 1'b1;
    cycles(2);
    wdt_timeout = 1'b0;
    for (int i = 0; i < 6; i++) begin
      cycles(1);
      if (done_o) dseen++;
    end
    check("R7 hold mid count", int'(hold_rst), 1);
    check("R7 no early done", dseen, 0);
    fire(1, LAT, 1, "R7 restart");
  endtask

  task automatic t_power_loss;
    int dseen = 0;
    wdt_timeout = 1'b1;
    cycles(4);
    wdt_timeout = 1'b0;
    pwr_ok = 1'b0;
    #1;
    check("R8 hold before edge", int'(hold_rst), 1);
    @(negedge clk);
    wdt_timeout = 1'b1;
    stop_recover = 1'b1;
    for (int i = 0; i < LAT + 5; i++) begin
      cycles(1);
      if (done_o) dseen++;
      if (!hold_rst) dseen += 100;
    end
    wdt_timeout = 1'b0;
    stop_recover = 1'b0;
    check("R8 held, no done while power low", dseen, 0);
    cycles(3);
    fire(0, LAT, 1, "R8 return");
  endtask

  task automatic t_level_held;
    int dseen = 0, hi_end = 0;
    wdt_timeout = 1'b1;
    for (int i = 0; i < 3 * LAT; i++) begin
      cycles(1);
      if (done_o) dseen++;
    end
    hi_end = int'(hold_rst);
    check("R10 held level one pulse", dseen, 1);
    check("R10 released while held", hi_end, 0);
    wdt_timeout = 1'b0;
    dseen = 0;
    for (int i = 0; i < LAT; i++) begin
      cycles(1);
      if (done_o || hold_rst) dseen++;
    end
    check("R10 falling edge ignored", dseen, 0);
  endtask

  initial begin
    cycles(1);
    t_reset();
    t_watchdog();
    t_stop_delay();
    t_stop_bypass();
    t_no_shortcut();
    t_retrigger();
    t_power_loss();
    t_level_held();
    check("R9 idle done low", int'(done_o), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule